// File: doc/BRIEF.md
# Register Pointer with Wrapping Auto-Increment

This block keeps the register pointer of a register file that is written and read over a two-wire serial bus. The byte-level front end sends it one strobe per data byte. The byte that follows an address match carries a flag that marks it as the control byte. The block takes that byte as a control value. Its low six bits give the target register. Bit 7 turns auto-increment on. Bit 6 is reserved and must be zero. A control byte that names a reserved address, or that has bit 6 set, is refused. The bytes after a refused control byte are refused too, until a new control byte is accepted.

After each accepted data byte, or each read byte that the master acknowledges, the pointer moves on according to a two-bit scheme select. The select comes from a mode register held elsewhere. The four schemes cover different ranges: the whole map 00h–26h, the brightness bank 02h–19h, the two group-control registers 1Ah–1Bh, and the brightness bank together with the group registers, 02h–1Bh. At the top of its range the pointer returns to the bottom of that range. When auto-increment is off, the pointer stays where it is, so repeated bytes all go to the same register. The block gives the write address together with a write strobe, and a one-cycle accept or refuse pulse for each byte. The register contents and the bus bit timing live outside the block.

Top module: `reg_ptr_ctl`

## Requirements
- R1: After reset, reg_addr is 00h, ai_flag is 0, and wr_stb, ack and nack are all 0.
- R2: A control byte (byte_stb with first_byte) that has bit 6 = 0 and bits [5:0] ≤ 26h is accepted. In the next cycle ack pulses, reg_addr equals bits [5:0], ai_flag equals bit 7, and wr_stb stays 0.
- R3: A control byte with bit 6 = 1 or with bits [5:0] ≥ 27h is refused. nack pulses and reg_addr and ai_flag do not change. Every later data byte is answered with nack and no wr_stb, and read strobes do not move the pointer, until a control byte is accepted.
- R4: A data byte (byte_stb without first_byte) that is not blocked gives, one cycle later, wr_stb = 1 and ack = 1, with wr_addr equal to reg_addr as it was before the byte.
- R5: With ai_flag = 0, data bytes and read strobes leave reg_addr unchanged.
- R6: With ai_flag = 1 and scheme = 0, each step adds one, and 26h goes back to 00h.
- R7: With ai_flag = 1 and scheme = 1, the pointer cycles through 02h–19h. From 19h, or from any value outside that range, the next step goes to 02h.
- R8: With ai_flag = 1 and scheme = 2, the pointer cycles through 1Ah–1Bh. From 1Bh, or from outside that range, the next step goes to 1Ah.
- R9: With ai_flag = 1 and scheme = 3, the pointer cycles through 02h–1Bh. From 1Bh, or from outside that range, the next step goes to 02h.
- R10: A read strobe (rd_stb without byte_stb) moves the pointer exactly as a data byte would, and does not raise wr_stb, ack or nack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_stb | input | 1 | One-cycle strobe: a written byte is present on byte_in |
| first_byte | input | 1 | Qualifies byte_stb: the byte is the control byte |
| byte_in | input | 8 | Received byte |
| rd_stb | input | 1 | One-cycle strobe: the master acknowledged a byte that was read |
| scheme | input | 2 | Auto-increment range select (0 all, 1 brightness, 2 group, 3 brightness+group) |
| reg_addr | output | 6 | Current register pointer |
| ai_flag | output | 1 | Auto-increment enable from the last accepted control byte |
| wr_stb | output | 1 | Write pulse for the register file |
| wr_addr | output | 6 | Register address for wr_stb |
| ack | output | 1 | Byte accepted pulse |
| nack | output | 1 | Byte refused pulse |

## Verification
The hardest state to reach is a pointer that sits outside the range of the scheme in force when it steps. The pointer can only get there through a control byte whose address lies outside that range. The bench therefore loads every legal start address under each of the four schemes and then steps several times, so each range entry, each in-range step and each wrap is exercised. A sweep over all 256 control byte values, each followed by a data byte, reaches the blocked state from every refused value. A separate run checks that reads done while blocked leave the pointer where it is.

// File: rtl/reg_ptr_ctl.sv
module reg_ptr_ctl #(
  parameter int DW       = 8,
  parameter int LAST_REG = 38,
  parameter int BRT_LO   = 2,
  parameter int BRT_HI   = 25,
  parameter int GRP_LO   = 26,
  parameter int GRP_HI   = 27,
  localparam int AW      = DW - 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_stb,
  input  logic          first_byte,
  input  logic [DW-1:0] byte_in,
  input  logic          rd_stb,
  input  logic [1:0]    scheme,
  output logic [AW-1:0] reg_addr,
  output logic          ai_flag,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic          ack,
  output logic          nack
);

  localparam logic [AW-1:0] LAST_A = AW'(LAST_REG);

  logic [AW-1:0] ptr, lo, hi, nxt;
  logic          blocked;

  wire ctl_ok = !byte_in[DW-2] && (byte_in[AW-1:0] <= LAST_A);

  always_comb begin
    case (scheme)
      2'd0:    begin lo = '0;          hi = LAST_A;       end
      2'd1:    begin lo = AW'(BRT_LO); hi = AW'(BRT_HI); end
      2'd2:    begin lo = AW'(GRP_LO); hi = AW'(GRP_HI); end
      default: begin lo = AW'(BRT_LO); hi = AW'(GRP_HI); end
    endcase
    if (!ai_flag)                 nxt = ptr;
    else if (ptr < lo || ptr >= hi) nxt = lo;
    else                          nxt = ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      ai_flag <= 1'b0;
      blocked <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      ack     <= 1'b0;
      nack    <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      ack    <= 1'b0;
      nack   <= 1'b0;
      if (byte_stb && first_byte) begin
        if (ctl_ok) begin
          ptr     <= byte_in[AW-1:0];
          ai_flag <= byte_in[DW-1];
          blocked <= 1'b0;
          ack     <= 1'b1;
        end else begin
          blocked <= 1'b1;
          nack    <= 1'b1;
        end
      end else if (byte_stb) begin
        if (blocked) nack <= 1'b1;
        else begin
          wr_stb  <= 1'b1;
          wr_addr <= ptr;
          ack     <= 1'b1;
          ptr     <= nxt;
        end
      end else if (rd_stb && !blocked) begin
        ptr <= nxt;
      end
    end
  end

  assign reg_addr = ptr;

  // R4
  wr_has_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (ack && !nack));

  // R4
  wr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && !first_byte && !blocked) |=> (wr_addr == $past(reg_addr)));

  // R3
  refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && first_byte && byte_in[DW-2]) |=> (nack && $stable(reg_addr) && $stable(ai_flag)));

  // R5
  no_ai_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!first_byte && !ai_flag && (byte_stb || rd_stb)) |=> $stable(reg_addr));

  // R6
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr <= LAST_A);

  // R8
  grp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ai_flag && scheme == 2'd2 && rd_stb && !byte_stb && !blocked)
      |=> (reg_addr == AW'(GRP_LO) || reg_addr == AW'(GRP_HI)));

  // R10
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !byte_stb) |=> (!wr_stb && !ack && !nack));

endmodule

// File: tb/tb_reg_ptr_ctl.sv
module tb_reg_ptr_ctl;
  logic clk = 0, rst_n = 0;
  logic byte_stb = 0, first_byte = 0, rd_stb = 0;
  logic [7:0] byte_in = 0;
  logic [1:0] scheme = 0;
  logic [5:0] reg_addr, wr_addr;
  logic ai_flag, wr_stb, ack, nack;
  int n_chk = 0, n_fail = 0;
  int m_ptr = 0, m_flag = 0, m_blk = 0;

  always #2.5 clk = ~clk;

  reg_ptr_ctl dut (.clk, .rst_n, .byte_stb, .first_byte, .byte_in, .rd_stb, .scheme,
    .reg_addr, .ai_flag, .wr_stb, .wr_addr, .ack, .nack);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int nxt_of(int p, int f, int s);
    int lo, hi;
    if (f == 0) return p;
    case (s)
      0: begin lo = 0;  hi = 38; end
      1: begin lo = 2;  hi = 25; end
      2: begin lo = 26; hi = 27; end
      default: begin lo = 2; hi = 27; end
    endcase
    if (p < lo || p >= hi) return lo;
    return p + 1;
  endfunction

  function automatic string step_tag(int f, int s);
    if (f == 0) return "R5";
    case (s) 0: return "R6"; 1: return "R7"; 2: return "R8"; default: return "R9"; endcase
  endfunction

  // kind: 0 control byte, 1 data byte, 2 read strobe
  task automatic op(input int kind, input logic [7:0] d);
    int e_ack = 0, e_nack = 0, e_wr = 0, e_wa = 0;
    string tag;
    @(negedge clk);
    byte_stb = (kind != 2); first_byte = (kind == 0); rd_stb = (kind == 2); byte_in = d;
    if (kind == 0) begin
      if (!d[6] && d[5:0] <= 38) begin
        e_ack = 1; m_ptr = d[5:0]; m_flag = d[7]; m_blk = 0; tag = "R2";
      end else begin
        e_nack = 1; m_blk = 1; tag = "R3";
      end
    end else if (kind == 1) begin
      if (m_blk) begin e_nack = 1; tag = "R3"; end
      else begin
        e_ack = 1; e_wr = 1; e_wa = m_ptr; tag = step_tag(m_flag, scheme);
        m_ptr = nxt_of(m_ptr, m_flag, scheme);
      end
    end else begin
      tag = m_blk ? "R3" : "R10";
      if (!m_blk) m_ptr = nxt_of(m_ptr, m_flag, scheme);
    end
    @(posedge clk); #1;
    byte_stb = 0; first_byte = 0; rd_stb = 0;
    check(ack == e_ack, tag, ack, e_ack);
    check(nack == e_nack, tag, nack, e_nack);
    check(wr_stb == e_wr, tag, wr_stb, e_wr);
    if (e_wr) check(wr_addr == e_wa, "R4", wr_addr, e_wa);
    check(reg_addr == m_ptr, tag, reg_addr, m_ptr);
    check(ai_flag == m_flag, tag, ai_flag, m_flag);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(reg_addr == 0 && ai_flag == 0 && !wr_stb && !ack && !nack, "R1", reg_addr, 0);
    @(negedge clk); rst_n = 1;
    // R2 / R3 control sweep, each followed by a data byte
    scheme = 0;
    for (int c = 0; c < 256; c++) begin
      op(0, 8'(c));
      op(1, 8'hA5);
    end
    // R6..R9 every start address under every scheme
    for (int s = 0; s < 4; s++) begin
      scheme = 2'(s);
      for (int p = 0; p <= 38; p++) begin
        op(0, {2'b10, 6'(p)});
        op(1, 8'h11); op(1, 8'h22); op(2, 8'h00); op(1, 8'h33); op(2, 8'h00);
      end
    end
    // R5 auto-increment off
    scheme = 3;
    op(0, 8'h05); op(1, 8'h01); op(2, 8'h00); op(1, 8'h02);
    // R3 reads while blocked do not move pointer
    scheme = 0;
    op(0, 8'h83); op(1, 8'h00);
    op(0, 8'h27); op(2, 8'h00); op(2, 8'h00); op(1, 8'h00);
    op(0, 8'h84); op(2, 8'h00);
    // R10 read wraps at top of full map
    op(0, 8'hA6); op(2, 8'h00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule